// File: doc/BRIEF.md
# Multicore coherence control register block

This block is the register front end of a multicore coherence controller. It answers a small memory-mapped window of 256 bytes on a simple bus. The bus carries an address, a read strobe, a write strobe, write data and a transfer size of 1, 2 or 4 bytes. The block returns read data one clock after each read strobe. It holds three things: a one-bit enable register, a read-only configuration word built from the core count, and a 32-bit power status word that can be written a byte lane at a time.

The core count is fixed when the block is elaborated. If the count parameter is left at zero, a second parameter supplies a platform default. The configuration word shows one present bit per core starting at bit 4, and the core count minus one in bits 1:0.

Every offset that is not decoded reads as zero and ignores writes. A write whose transfer size is not one of the three legal values changes no register.

Top module: `coh_ctl_regs`

## Requirements
- R1: Reads at any offset other than 0x00, 0x04 and 0x08 to 0x0B return zero, including 0x0C, 0x40, 0x44, 0x50 and 0x54. Writes to those offsets change no register that can be read back.
- R2: A legal-size write to offset 0x00 stores only bit 0 of the write data. A read of 0x00 returns that bit in bit 0 and zeros in bits 31:1.
- R3: A read of offset 0x04 returns ((2^N - 1) << 4) | (N - 1), where N is the core count. With the default N = 2 this is 0x31. Writes to 0x04 have no effect.
- R4: A read at offset 0x08 + k, for k from 0 to 3, returns the status word shifted right by 8*k bits, with zeros filled in from the top.
- R5: A legal-size write at offset 0x08 + k replaces status bits under the mask M << 8k with (wdata & M) << 8k. M is 0xFF for size 1, 0xFFFF for size 2 and 0xFFFFFFFF for size 4. The other status bits are kept.
- R6: Status write lanes that would land above bit 31 are dropped. For example, a 4-byte write at 0x0B changes only bits 31:24.
- R7: A write whose size code is not 1, 2 or 4 changes neither the control bit nor the status word.
- R8: While reset is asserted, the control bit, the status word and the read data are all zero.
- R9: Read data is registered. It is valid in the clock after the read strobe and holds its value in cycles without a read strobe. A read and a write to the same offset in one cycle return the value held before the write.
- R10: When the core-count parameter is zero, the default core count is used in its place. With the default of 4 cores, offset 0x04 reads 0xF3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | AW (8) | Byte offset within the window |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wsize | input | 3 | Transfer size in bytes (1, 2 or 4 are legal) |
| wdata | input | DW (32) | Write data, right-aligned |
| rdata | output | DW (32) | Registered read data |

## Verification
The assertions take for granted that every input is at a known 0 or 1 at each rising edge. They also take for granted that an address is only meaningful while a strobe is high, so none of them looks at the address on idle cycles. The bench drives every input at the falling edge, so each value is settled well before the rising edge. The stimulus deliberately covers illegal size codes, simultaneous read and write, and offsets outside the decoded set. This keeps the rejection and hold properties under real load rather than leaving them untested.

// File: rtl/coh_ctl_regs.sv
module coh_ctl_regs #(
  parameter int NCPU      = 2,
  parameter int DFLT_NCPU = 4,
  parameter int AW        = 8,
  parameter int DW        = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [2:0]    wsize,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int            NC       = (NCPU == 0) ? DFLT_NCPU : NCPU;
  localparam int            CFG_I    = (((1 << NC) - 1) << 4) | (NC - 1);
  localparam logic [DW-1:0] CFG_WORD = DW'(CFG_I);
  localparam logic [AW-1:0] OFS_CTRL = AW'(0);
  localparam logic [AW-1:0] OFS_CFG  = AW'(4);
  localparam logic [AW-1:0] OFS_STAT = AW'(8);

  logic          ctrl;
  logic [DW-1:0] status;
  logic [DW-1:0] lane_mask, wmask, wval, rd_mux;
  logic [1:0]    lane;
  logic          size_ok, in_stat;

  assign lane    = addr[1:0];
  assign in_stat = (addr[AW-1:2] == OFS_STAT[AW-1:2]);
  assign size_ok = (wsize == 3'd1) || (wsize == 3'd2) || (wsize == 3'd4);

  always_comb begin
    case (wsize)
      3'd1:    lane_mask = DW'(32'h0000_00FF);
      3'd2:    lane_mask = DW'(32'h0000_FFFF);
      default: lane_mask = {DW{1'b1}};
    endcase
  end

  assign wmask = lane_mask << {lane, 3'b000};
  assign wval  = (wdata & lane_mask) << {lane, 3'b000};

  always_comb begin
    if (addr == OFS_CTRL)     rd_mux = DW'(ctrl);
    else if (addr == OFS_CFG) rd_mux = CFG_WORD;
    else if (in_stat)         rd_mux = status >> {lane, 3'b000};
    else                      rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl   <= 1'b0;
      status <= '0;
      rdata  <= '0;
    end else begin
      if (rd_en) rdata <= rd_mux;
      if (wr_en && size_ok) begin
        if (addr == OFS_CTRL) ctrl <= wdata[0];
        if (in_stat)          status <= (status & ~wmask) | wval;
      end
    end
  end
endmodule

module coh_ctl_regs_chk #(
  parameter int            AW  = 8,
  parameter int            DW  = 32,
  parameter logic [DW-1:0] CFG = '0
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          rd_en,
  input logic          wr_en,
  input logic [2:0]    wsize,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic          ctrl,
  input logic [DW-1:0] status
);
  logic legal, mapped;
  assign legal  = (wsize == 3'd1) || (wsize == 3'd2) || (wsize == 3'd4);
  assign mapped = (addr == AW'(0)) || (addr == AW'(4)) || (addr[AW-1:2] == (AW-2)'(2));

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !mapped |=> rdata == '0);                                    // R1
  AST_CTRL_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && legal && addr == AW'(0) |=> ctrl == $past(wdata[0]));        // R2
  AST_CTRL_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr == AW'(0) |=> rdata == DW'($past(ctrl)));               // R2
  AST_CFG_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr == AW'(4) |=> rdata == CFG);                            // R3
  AST_BAD_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !legal |=> $stable(status) && $stable(ctrl));                // R7
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));                                           // R9
endmodule

bind coh_ctl_regs coh_ctl_regs_chk #(.AW(AW), .DW(DW), .CFG(CFG_WORD)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
  .wsize(wsize), .wdata(wdata), .rdata(rdata), .ctrl(ctrl), .status(status)
);

// File: tb/sim_coh_ctl_regs.sv
`timescale 1ns/100ps
module sim_coh_ctl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [2:0]  wsize = 3'd4;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_d;

  int vecs = 0, miss = 0;
  bit done = 0;

  bit          m_ctrl;
  logic [31:0] m_stat, m_rd;

  always #2.5 clk = ~clk;

  coh_ctl_regs #(.NCPU(2)) u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en),
    .wr_en(wr_en), .wsize(wsize), .wdata(wdata), .rdata(rdata));
  coh_ctl_regs #(.NCPU(0), .DFLT_NCPU(4)) u1 (.clk(clk), .rst_n(rst_n), .addr(addr),
    .rd_en(rd_en), .wr_en(wr_en), .wsize(wsize), .wdata(wdata), .rdata(rdata_d));

  function automatic logic [31:0] cfg_of(int n);
    logic [31:0] v = 0;
    for (int i = 0; i < n; i++) v[4+i] = 1'b1;
    v[1:0] = 2'(n - 1);
    return v;
  endfunction

  function automatic logic [31:0] model_read(logic [7:0] a);
    case (a)
      8'h00: return {31'b0, m_ctrl};
      8'h04: return cfg_of(2);
      8'h08: return m_stat;
      8'h09: return m_stat / 256;
      8'h0A: return m_stat / 65536;
      8'h0B: return m_stat / 16777216;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(bit rd, bit wr, logic [7:0] a, logic [2:0] sz, logic [31:0] d, string req);
    rd_en = rd; wr_en = wr; addr = a; wsize = sz; wdata = d;
    @(posedge clk);
    if (rd) m_rd = model_read(a);
    if (wr && (sz == 1 || sz == 2 || sz == 4)) begin
      if (a == 8'h00) m_ctrl = d[0];
      if (a >= 8'h08 && a <= 8'h0B) begin
        for (int b = 0; b < 32; b++) begin
          int src = b - 8 * int'(a - 8'h08);
          int lim = (sz == 1) ? 8 : (sz == 2) ? 16 : 32;
          if (src >= 0 && src < lim) m_stat[b] = d[src];
        end
      end
    end
    @(negedge clk);
    check(req, rdata, m_rd);
    rd_en = 0; wr_en = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miss++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end

  initial begin
    logic [7:0] alist [12] = '{8'h00, 8'h04, 8'h08, 8'h09, 8'h0A, 8'h0B,
                               8'h0C, 8'h40, 8'h44, 8'h50, 8'h54, 8'hFF};
    logic [2:0] slist [6] = '{3'd1, 3'd2, 3'd4, 3'd0, 3'd3, 3'd7};
    m_ctrl = 0; m_stat = 0; m_rd = 0;
    repeat (3) @(negedge clk);
    check("R8 rdata in reset", rdata, 32'h0);
    wr_en = 1; addr = 8'h08; wsize = 3'd4; wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    wr_en = 0;
    rst_n = 1'b1;
    step(1, 0, 8'h08, 3'd4, 0, "R8 status cleared");
    step(1, 0, 8'h00, 3'd4, 0, "R8 control cleared");

    step(0, 1, 8'h00, 3'd4, 32'hFFFF_FFFE, "R2 write");
    step(1, 0, 8'h00, 3'd4, 0, "R2 read zero");
    step(0, 1, 8'h00, 3'd1, 32'h0000_0003, "R2 write");
    step(1, 0, 8'h00, 3'd4, 0, "R2 read one");

    step(1, 0, 8'h04, 3'd4, 0, "R3 config");
    check("R10 default core count", rdata_d, 32'h0000_00F3);
    step(0, 1, 8'h04, 3'd4, 32'hDEAD_BEEF, "R3 write ignored");
    step(1, 0, 8'h04, 3'd4, 0, "R3 config after write");

    step(0, 1, 8'h08, 3'd4, 32'h1122_3344, "R5 word");
    step(1, 0, 8'h08, 3'd4, 0, "R5 word read");
    step(0, 1, 8'h09, 3'd1, 32'hFFFF_FFAA, "R5 byte");
    step(1, 0, 8'h08, 3'd4, 0, "R5 byte read");
    check("R5 byte merge", m_rd, 32'h1122_AA44);
    step(1, 0, 8'h0A, 3'd4, 0, "R4 shift 16");
    step(0, 1, 8'h0A, 3'd2, 32'h1234_5566, "R5 half");
    step(1, 0, 8'h0B, 3'd4, 0, "R4 shift 24");
    check("R4 top byte", m_rd, 32'h0000_0055);
    step(0, 1, 8'h0B, 3'd4, 32'hFFFF_FF77, "R6 truncate");
    step(1, 0, 8'h08, 3'd4, 0, "R6 read");
    check("R6 value", m_rd, 32'h7766_AA44);

    step(0, 1, 8'h08, 3'd3, 32'h0, "R7 size 3");
    step(0, 1, 8'h08, 3'd0, 32'h0, "R7 size 0");
    step(0, 1, 8'h00, 3'd7, 32'h0, "R7 ctrl size 7");
    step(1, 0, 8'h08, 3'd4, 0, "R7 status kept");
    step(1, 0, 8'h00, 3'd4, 0, "R7 control kept");

    step(1, 1, 8'h08, 3'd4, 32'h0BAD_F00D, "R9 read old on write");
    step(0, 0, 8'h00, 3'd4, 0, "R9 hold");
    step(0, 1, 8'h00, 3'd4, 0, "R9 hold under write");

    step(0, 1, 8'h0C, 3'd4, 32'hFFFF_FFFF, "R1 write 0C");
    step(0, 1, 8'h40, 3'd4, 32'hFFFF_FFFF, "R1 write 40");
    step(1, 0, 8'h0C, 3'd4, 0, "R1 read 0C");
    step(1, 0, 8'h54, 3'd4, 0, "R1 read 54");
    step(1, 0, 8'h08, 3'd4, 0, "R1 status untouched");

    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a;
      a = ($urandom % 4 == 0) ? 8'($urandom) : alist[$urandom % 12];
      step(1'($urandom), 1'($urandom), a, slist[$urandom % 6], $urandom, "R1-R9 mixed");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule